// File: doc/BRIEF.md
# Galloping Row/Column Memory Test Engine

This block is a built-in self-test sequencer for a memory whose address is split into a row field and a column field. It runs a galloping (ping-pong) pattern: every address in turn becomes the test cell. The test cell is set to the inverse of the background word. It is then read alternately with each other cell that shares its row (row mode) or its column (column mode). At the end it is restored to the background.

A run has two passes. The first pass uses an all-zeros background and the second uses an all-ones background. Each pass begins by filling the whole array with its background. The engine drives a simple synchronous memory port: one write or one read per cycle, with read data due one cycle after the read strobe. It compares every returned word against the value it expects. The first mismatch is kept for diagnosis, and a one-cycle done pulse closes the run.

Top module: `gb_engine`

## Requirements
- R1: The cycle after a start is accepted, the engine writes the background word to addresses 0 up to the last address, one per cycle in ascending order. The background is all zeros in the first pass.
- R2: After the fill, the test cell starts at address 0 and each test cell is first written with the inverted background word.
- R3: For each partner, the engine reads the partner and expects the background, then reads the test cell and expects the inverted background. Partner indices run upward from 0, and the test cell's own index is skipped.
- R4: The address is {row, column}. With row_mode=1 the partner index steps the column field at the test cell's row. With row_mode=0 it steps the row field at the test cell's column.
- R5: After the last partner pair, the test cell is rewritten with the background, and the next address becomes the test cell.
- R6: After the last test cell of the first pass, the whole sequence repeats with an all-ones background. done is high for exactly the one cycle after the final restore write of the second pass.
- R7: start and row_mode are sampled only while idle. Changes to either during a run have no effect on the access sequence.
- R8: Read data is compared one cycle after mem_re. The first mismatch captures the read address, the expected word and the actual word, and sets fail. fail and the captured values stay unchanged by later mismatches until the next accepted start.
- R9: Accepting a start clears fail.
- R10: After reset the engine is idle: busy, done, fail, mem_we and mem_re are all low.
- R11: mem_we and mem_re are never high together. While busy, every cycle except the done cycle carries exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| row_mode | input | 1 | 1 = gallop along the row, 0 = along the column; sampled at start |
| mem_addr | output | ROW_W+COL_W | Memory address {row, column} |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after mem_re |
| busy | output | 1 | Run in progress, including the done cycle |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ROW_W+COL_W | Address of the first mismatching read |
| fail_exp | output | DATA_W | Expected word of the first mismatch |
| fail_act | output | DATA_W | Returned word of the first mismatch |

## Verification
The assertions check the following on every cycle:
- reads and writes never overlap, and the engine stays silent while idle;
- a busy cycle always carries an access;
- done is a single-cycle pulse;
- an accepted start clears fail and opens with a write of zeros to address 0;
- fail and its captured address stay unchanged until the next start.

The exact order of accesses is shown only by the bench's cycle-by-cycle comparison against an independently generated access list. That order covers the fill, the partner order with the self-skip, the row versus column address formation and the second pass. The same holds for the first-failure capture, which the bench predicts from its own faulty memory model, and for the immunity to start and mode changes during a run.

// File: rtl/gb_pkg.sv
package gb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FILL = 3'd1,
        ST_MARK = 3'd2,
        ST_PEER = 3'd3,
        ST_SELF = 3'd4,
        ST_HEAL = 3'd5,
        ST_END  = 3'd6
    } gb_state_e;

endpackage

// File: rtl/gb_seq.sv
module gb_seq
    import gb_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              row_mode,
    output logic [ROW_W+COL_W-1:0] op_addr,
    output logic              op_we,
    output logic              op_re,
    output logic [DATA_W-1:0] op_wdata,
    output logic [DATA_W-1:0] op_exp,
    output logic              op_clr,
    output logic              run_busy,
    output logic              run_done
);

    localparam int AW    = ROW_W + COL_W;
    localparam int MAXW  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int IW    = MAXW + 1;
    localparam int ROW_N = 1 << ROW_W;
    localparam int COL_N = 1 << COL_W;
    localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

    typedef struct packed {
        gb_state_e       st;
        logic [AW-1:0]   tc;
        logic [IW-1:0]   pi;
        logic            bg;
        logic            pass;
        logic            mode;
    } seq_t;

    seq_t s_d, s_q;

    logic [ROW_W-1:0]  tc_row;
    logic [COL_W-1:0]  tc_col;
    logic [IW-1:0]     own_idx;
    logic [IW-1:0]     last_idx;
    logic [IW-1:0]     first_idx;
    logic [IW-1:0]     step_idx;
    logic [IW-1:0]     next_idx;
    logic [AW-1:0]     peer_addr;
    logic [DATA_W-1:0] bg_word;

    always_comb begin
        tc_row    = s_q.tc[AW-1:COL_W];
        tc_col    = s_q.tc[COL_W-1:0];
        own_idx   = s_q.mode ? IW'(tc_col) : IW'(tc_row);
        last_idx  = s_q.mode ? IW'(COL_N - 1) : IW'(ROW_N - 1);
        first_idx = (own_idx == '0) ? IW'(1) : '0;
        step_idx  = s_q.pi + IW'(1);
        next_idx  = (step_idx == own_idx) ? (s_q.pi + IW'(2)) : step_idx;
        peer_addr = s_q.mode ? {tc_row, s_q.pi[COL_W-1:0]}
                             : {s_q.pi[ROW_W-1:0], tc_col};
        bg_word   = {DATA_W{s_q.bg}};
    end

    always_comb begin
        s_d      = s_q;
        op_addr  = '0;
        op_we    = 1'b0;
        op_re    = 1'b0;
        op_wdata = '0;
        op_exp   = '0;
        op_clr   = 1'b0;
        run_busy = (s_q.st != ST_IDLE);
        run_done = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    op_clr    = 1'b1;
                    s_d.mode  = row_mode;
                    s_d.bg    = 1'b0;
                    s_d.pass  = 1'b0;
                    s_d.tc    = '0;
                    s_d.pi    = '0;
                    s_d.st    = ST_FILL;
                end
            end
            ST_FILL: begin
                op_we    = 1'b1;
                op_addr  = s_q.tc;
                op_wdata = bg_word;
                s_d.tc   = s_q.tc + AW'(1);
                if (s_q.tc == LAST_ADDR) begin
                    s_d.st = ST_MARK;
                end
            end
            ST_MARK: begin
                op_we    = 1'b1;
                op_addr  = s_q.tc;
                op_wdata = ~bg_word;
                s_d.pi   = first_idx;
                s_d.st   = ST_PEER;
            end
            ST_PEER: begin
                op_re   = 1'b1;
                op_addr = peer_addr;
                op_exp  = bg_word;
                s_d.st  = ST_SELF;
            end
            ST_SELF: begin
                op_re   = 1'b1;
                op_addr = s_q.tc;
                op_exp  = ~bg_word;
                if (next_idx > last_idx) begin
                    s_d.st = ST_HEAL;
                end else begin
                    s_d.pi = next_idx;
                    s_d.st = ST_PEER;
                end
            end
            ST_HEAL: begin
                op_we    = 1'b1;
                op_addr  = s_q.tc;
                op_wdata = bg_word;
                s_d.tc   = s_q.tc + AW'(1);
                if (s_q.tc == LAST_ADDR) begin
                    if (!s_q.pass) begin
                        s_d.pass = 1'b1;
                        s_d.bg   = 1'b1;
                        s_d.st   = ST_FILL;
                    end else begin
                        s_d.st = ST_END;
                    end
                end else begin
                    s_d.st = ST_MARK;
                end
            end
            ST_END: begin
                run_done = 1'b1;
                s_d.st   = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, tc: '0, pi: '0, bg: 1'b0, pass: 1'b0, mode: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/gb_cmp.sv
module gb_cmp #(
    parameter int AW     = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    input  logic [DATA_W-1:0] rd_exp,
    input  logic [DATA_W-1:0] rd_data,
    output logic              fail,
    output logic [AW-1:0]     fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_act
);

    typedef struct packed {
        logic              pend;
        logic [AW-1:0]     paddr;
        logic [DATA_W-1:0] pexp;
        logic              bad;
        logic [AW-1:0]     faddr;
        logic [DATA_W-1:0] fexp;
        logic [DATA_W-1:0] fact;
    } cmp_t;

    cmp_t c_d, c_q;
    logic mismatch;

    always_comb begin
        c_d       = c_q;
        c_d.pend  = rd_en;
        c_d.paddr = rd_addr;
        c_d.pexp  = rd_exp;
        mismatch  = c_q.pend && (rd_data != c_q.pexp);
        if (clr) begin
            c_d.bad   = 1'b0;
            c_d.faddr = '0;
            c_d.fexp  = '0;
            c_d.fact  = '0;
        end else if (mismatch && !c_q.bad) begin
            c_d.bad   = 1'b1;
            c_d.faddr = c_q.paddr;
            c_d.fexp  = c_q.pexp;
            c_d.fact  = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign fail      = c_q.bad;
    assign fail_addr = c_q.faddr;
    assign fail_exp  = c_q.fexp;
    assign fail_act  = c_q.fact;

endmodule

// File: rtl/gb_engine.sv
module gb_engine #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   row_mode,
    output logic [ROW_W+COL_W-1:0] mem_addr,
    output logic                   mem_we,
    output logic                   mem_re,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   busy,
    output logic                   done,
    output logic                   fail,
    output logic [ROW_W+COL_W-1:0] fail_addr,
    output logic [DATA_W-1:0]      fail_exp,
    output logic [DATA_W-1:0]      fail_act
);

    localparam int AW = ROW_W + COL_W;

    logic [DATA_W-1:0] op_exp;
    logic              op_clr;

    gb_seq #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .row_mode (row_mode),
        .op_addr  (mem_addr),
        .op_we    (mem_we),
        .op_re    (mem_re),
        .op_wdata (mem_wdata),
        .op_exp   (op_exp),
        .op_clr   (op_clr),
        .run_busy (busy),
        .run_done (done)
    );

    gb_cmp #(
        .AW     (AW),
        .DATA_W (DATA_W)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (op_clr),
        .rd_en     (mem_re),
        .rd_addr   (mem_addr),
        .rd_exp    (op_exp),
        .rd_data   (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp),
        .fail_act  (fail_act)
    );

endmodule

// File: rtl/gb_engine_chk.sv
module gb_engine_chk #(
    parameter int AW     = 7,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic              mem_re,
    input logic [AW-1:0]     mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              fail,
    input logic [AW-1:0]     fail_addr
);

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R11

    AST_BUSY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> (mem_we || mem_re)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re && !done)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_START_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && mem_we && mem_addr == '0 && mem_wdata == '0)); // R1

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !fail); // R9

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(start && !busy)) |=> fail); // R8

    AST_FAIL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(start && !busy)) |=> $stable(fail_addr)); // R8

endmodule

bind gb_engine gb_engine_chk #(
    .AW     (ROW_W + COL_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .fail      (fail),
    .fail_addr (fail_addr)
);

// File: tb/gb_engine_tb.sv
module gb_engine_tb;

    localparam int ROW_W  = 4;
    localparam int COL_W  = 3;
    localparam int DATA_W = 8;
    localparam int AW     = ROW_W + COL_W;
    localparam int N      = 1 << AW;
    localparam int NR     = 1 << ROW_W;
    localparam int NC     = 1 << COL_W;
    localparam int ONES   = (1 << DATA_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic              row_mode;
    logic [AW-1:0]     mem_addr;
    logic              mem_we;
    logic              mem_re;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              busy;
    logic              done;
    logic              fail;
    logic [AW-1:0]     fail_addr;
    logic [DATA_W-1:0] fail_exp;
    logic [DATA_W-1:0] fail_act;

    always #5 clk = ~clk;

    gb_engine #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .row_mode(row_mode),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_exp(fail_exp), .fail_act(fail_act)
    );

    int total = 0;
    int bad   = 0;

    // environment memory with an optional stuck-at-0 bit 0 at one address
    logic [DATA_W-1:0] mem [N];
    bit fault_on = 0;
    int fault_at = 0;

    function automatic int rd_model(int a);
        int v;
        v = int'(mem[a]);
        if (fault_on && a == fault_at) v = v & ~1;
        return v;
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= DATA_W'(rd_model(int'(mem_addr)));
    end

    // expected access list
    int    q_w[$];
    int    q_a[$];
    int    q_d[$];
    string q_t[$];

    task automatic push(int w, int a, int d, string t);
        q_w.push_back(w); q_a.push_back(a); q_d.push_back(d); q_t.push_back(t);
    endtask

    task automatic build(bit mode);
        for (int pass = 0; pass < 2; pass++) begin
            int bg  = pass ? ONES : 0;
            int inv = bg ^ ONES;
            for (int a = 0; a < N; a++) push(1, a, bg, pass ? "R6" : "R1");
            for (int tc = 0; tc < N; tc++) begin
                int r = tc / NC;
                int c = tc % NC;
                push(1, tc, inv, "R2");
                if (mode) begin
                    for (int p = 0; p < NC; p++) if (p != c) begin
                        push(0, r * NC + p, bg, "R4");
                        push(0, tc, inv, "R3");
                    end
                end else begin
                    for (int p = 0; p < NR; p++) if (p != r) begin
                        push(0, p * NC + c, bg, "R4");
                        push(0, tc, inv, "R3");
                    end
                end
                push(1, tc, bg, "R5");
            end
        end
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic run(bit mode, bit f_en, int f_at, bit disturb);
        bit pf = 0;
        int pf_a = 0, pf_e = 0, pf_x = 0;
        int idx = 0;
        build(mode);
        fault_on = f_en;
        fault_at = f_at;
        @(negedge clk);
        start    = 1'b1;
        row_mode = mode;
        @(negedge clk);
        start    = 1'b0;
        row_mode = ~mode;           // R7: mode change after acceptance
        chk(fail == 1'b0, "R9", "fail after start", int'(fail), 0);
        while (q_w.size() > 0) begin
            int w = q_w.pop_front();
            int a = q_a.pop_front();
            int d = q_d.pop_front();
            string t = q_t.pop_front();
            bit ok;
            ok = (mem_we == w) && (mem_re == !w) && (int'(mem_addr) == a) && !done;
            if (w) ok = ok && (int'(mem_wdata) == d);
            chk(ok, t, $sformatf("op%0d we/re/addr", idx),
                {int'(mem_we), int'(mem_re), int'(mem_addr), int'(mem_wdata)},
                {w, int'(!w), a, w ? d : int'(mem_wdata)});
            if (!w && !pf) begin
                int x = rd_model(a);
                if (x != d) begin pf = 1; pf_a = a; pf_e = d; pf_x = x; end
            end
            if (disturb) begin       // R7: start pulses and mode flips mid-run
                start    = (idx % 97 == 5);
                row_mode = (idx % 53 < 20);
            end
            idx++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(done == 1'b1, "R6", "done at end", int'(done), 1);
        chk(fail == pf, "R8", "fail flag", int'(fail), int'(pf));
        if (pf) begin
            chk(int'(fail_addr) == pf_a, "R8", "fail_addr", int'(fail_addr), pf_a);
            chk(int'(fail_exp) == pf_e, "R8", "fail_exp", int'(fail_exp), pf_e);
            chk(int'(fail_act) == pf_x, "R8", "fail_act", int'(fail_act), pf_x);
        end
        @(negedge clk);
        chk(done == 1'b0, "R6", "done one cycle", int'(done), 0);
        chk(busy == 1'b0, "R6", "idle after done", int'(busy), 0);
        chk(!mem_we && !mem_re, "R11", "no access when idle",
            int'(mem_we) + int'(mem_re), 0);
        chk(fail == pf, "R8", "fail held after done", int'(fail), int'(pf));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        start    = 1'b0;
        row_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fail && !mem_we && !mem_re, "R10", "reset state",
            {int'(busy), int'(done), int'(fail), int'(mem_we), int'(mem_re)}, 0);
        // start held low: nothing happens
        repeat (2) @(negedge clk);
        chk(!busy && !mem_we, "R7", "idle without start", int'(busy), 0);

        run(1'b1, 1'b0, 0, 1'b0);    // row mode, clean
        run(1'b0, 1'b1, 37, 1'b0);   // column mode, stuck bit at 37
        run(1'b1, 1'b1, 90, 1'b1);   // row mode, fault, inputs disturbed
        run(1'b0, 1'b0, 0, 1'b1);    // column mode, clean, fail cleared

        summary();
        $finish;
    end

endmodule